// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static RAM built from 9-bit byte lanes. The word width is a parameter (18 bits gives two lanes, 36 bits gives four). Each command is sampled on a rising clock edge: chip select, write enable, address and per-lane write enables. For a write, the data does not arrive with the command. It is sampled on the next rising edge, and the write goes into the array on that edge.

Between the two edges the write is held in a small pending register. A read can be captured on the same edge that the pending write's data lands, at the same address. In that case the read is answered by forwarding: new bytes for the enabled lanes, array bytes for the others. Read data sits in an output register. That register is forced to zero on every cycle that issued no read.

A sleep input blocks new commands. A write whose data is due on the same edge still completes. Memory contents are kept through sleep, and the output reads zero during it.

Top module: `lw_sram`

## Requirements
- R1: While `rst` is high, `rd_data` becomes zero and any pending write is discarded. A write whose data edge falls inside reset leaves the array unchanged.
- R2: An edge with `sel`=1, `wr_en`=1 and `sleep`=0 queues a write to `addr`. The word on `wr_data` is sampled on the following rising edge and stored at that address.
- R3: An edge with `sel`=1, `wr_en`=0 and `sleep`=0 issues a read of `addr`. The stored word is on `rd_data` from that edge until the next edge.
- R4: `lane_en[i]` set to 1 writes bits `[9*i+8:9*i]` of the word. Lanes whose enable is 0 keep their previous contents.
- R5: A read issued on the edge where a pending write's data lands, at the same address, returns the new data in enabled lanes and the old array contents in the other lanes.
- R6: Writes issued on consecutive edges are all stored correctly, each with the data sampled one edge after its own command.
- R7: An edge with `sel`=0 queues no write and issues no read, whatever `wr_en`, `lane_en` and `wr_data` carry. `rd_data` is zero after it. An edge with a write command also leaves `rd_data` zero.
- R8: An edge with `sleep`=1 still stores the data of a write queued on the previous edge. It queues no write and issues no read. `rd_data` is zero after it. Contents are retained for later reads.
- R9: The number of lane enables is `WORD_W`/9. With the 36-bit default that is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Blocks new commands while high |
| sel | input | 1 | Chip select for the command on this edge |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| lane_en | input | WORD_W/9 | Per-lane write enables, sampled with the command |
| addr | input | log2(DEPTH) | Word address, sampled with the command |
| wr_data | input | WORD_W | Write data, sampled one edge after its command |
| rd_data | output | WORD_W | Registered read data, zero when no read was issued |

## Verification
The assertions take two things for granted: the control inputs are never X outside reset, and `DEPTH` is a power of two, so every `addr` value names a real word.

The forwarding property is only claimed when the earlier write enabled all lanes and the previous edge was outside reset. The bench drives every input half a period away from the sampling edge, which keeps the stimulus inside these conditions. It also writes every address once before any check reads the array. That means no comparison ever meets uninitialised storage.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic sel, input logic wr_en, input logic sleep);
        if (!sel || sleep) return OP_IDLE;
        return wr_en ? OP_WRITE : OP_READ;
    endfunction

    function automatic int lanes_of(input int width);
        return width / LANE_W;
    endfunction

endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [NB-1:0] lane_en,
    input  logic [AW-1:0] addr,
    output op_e           op,
    output logic          pend_vld,
    output logic [AW-1:0] pend_addr,
    output logic [NB-1:0] pend_be
);

    always_comb op = decode_op(sel, wr_en, sleep);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
        end else begin
            pend_vld  <= (op == OP_WRITE);
            pend_addr <= addr;
            pend_be   <= lane_en;
        end
    end

endmodule

// File: rtl/lw_lane.sv
module lw_lane
    import lw_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANE_W-1:0] wr_d,
    input  logic              rd_go,
    input  logic [AW-1:0]     rd_addr,
    output logic [LANE_W-1:0] q
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic              fwd;

    always_comb fwd = wr_go && (wr_addr == rd_addr);

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= wr_d;
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_go) q <= '0;
        else if (fwd)      q <= wr_d;
        else               q <= mem[rd_addr];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 1024,
    localparam int NB = lanes_of(WORD_W),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [NB-1:0]     lane_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    op_e           op;
    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic [NB-1:0] pend_be;
    logic          commit;
    logic          rd_go;

    lw_ctrl #(.AW(AW), .NB(NB)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .sel      (sel),
        .wr_en    (wr_en),
        .lane_en  (lane_en),
        .addr     (addr),
        .op       (op),
        .pend_vld (pend_vld),
        .pend_addr(pend_addr),
        .pend_be  (pend_be)
    );

    always_comb begin
        commit = pend_vld && !rst;
        rd_go  = (op == OP_READ);
    end

    for (genvar l = 0; l < NB; l++) begin : g_lane
        lw_lane #(.DEPTH(DEPTH)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .wr_go  (commit && pend_be[l]),
            .wr_addr(pend_addr),
            .wr_d   (wr_data[l*LANE_W +: LANE_W]),
            .rd_go  (rd_go),
            .rd_addr(addr),
            .q      (rd_data[l*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int WORD_W = 36,
    parameter int NB     = 4,
    parameter int AW     = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              sel,
    input logic              wr_en,
    input logic [NB-1:0]     lane_en,
    input logic [AW-1:0]     addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              pend_vld
);

    // R1: reset clears the output and the pending write
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0) && !pend_vld);

    // R7: no read command on an edge means a zero output after it
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr_en) |=> rd_data == '0);

    // R8: sleep forces a zero output
    p_sleep_zero_r8: assert property (@(posedge clk) disable iff (rst)
        sleep |=> rd_data == '0);

    // R8: sleep queues no write
    p_sleep_noqueue_r8: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !pend_vld);

    // R5: a read at the address of a full-word write landing now sees the new data
    p_bypass_full_r5: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && !sleep && $past(!rst) &&
         $past(sel && wr_en && !sleep && (&lane_en)) && (addr == $past(addr)))
        |=> rd_data == $past(wr_data));

endmodule

bind lw_sram lw_sram_chk #(.WORD_W(WORD_W), .NB(NB), .AW(AW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sleep   (sleep),
    .sel     (sel),
    .wr_en   (wr_en),
    .lane_en (lane_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pend_vld(pend_vld)
);

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;
    import lw_sram_pkg::*;

    localparam int W  = 36;
    localparam int D  = 64;
    localparam int NB = W / LANE_W;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic          sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [NB-1:0] lane_en = '0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;

    logic [W-1:0]  model [D];
    bit            pend_b = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [NB-1:0] pbe = '0;
    logic [W-1:0]  exp_q = '0;
    string         exp_tag = "R1 reset";

    always #2 clk = ~clk;

    lw_sram #(.WORD_W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .sleep(sleep), .sel(sel), .wr_en(wr_en),
        .lane_en(lane_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [W-1:0] merge(input logic [W-1:0] old_w,
                                           input logic [W-1:0] new_w,
                                           input logic [NB-1:0] be);
        logic [W-1:0] r = old_w;
        for (int l = 0; l < NB; l++)
            if (be[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic [W-1:0] init_pat(input int a);
        return W'(a * 36'h1_0203_0405) ^ 36'h5_5AA5_3C3C;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // one command per cycle; s_wd is the data for the command of the previous cycle
    task automatic step(input bit s_sl, input bit s_sel, input bit s_we,
                        input logic [NB-1:0] s_be, input logic [AW-1:0] s_a,
                        input logic [W-1:0] s_wd, input string tag);
        @(negedge clk);
        check(exp_tag, rd_data, exp_q);
        sleep = s_sl; sel = s_sel; wr_en = s_we; lane_en = s_be; addr = s_a; wr_data = s_wd;
        if (pend_b) model[pa] = merge(model[pa], s_wd, pbe);
        exp_q   = (s_sel && !s_we && !s_sl) ? model[s_a] : '0;
        exp_tag = tag;
        pend_b  = s_sel && s_we && !s_sl;
        pa      = s_a;
        pbe     = s_be;
    endtask

    task automatic t_init();
        for (int a = 0; a < D; a++)
            step(0, 1, 1, '1, AW'(a), init_pat(a - 1), "R2 init write");
        step(0, 0, 0, '0, '0, init_pat(D - 1), "R7 init flush");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 reset output", rd_data, '0);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        step(0, 1, 1, '1, 6'd5,  '0,             "R2 write 5");
        step(0, 1, 1, '1, 6'd63, 36'h1_2345_6789, "R2 write 63");
        step(0, 1, 0, '0, 6'd5,  36'hE_DCBA_9876, "R3 read 5");
        step(0, 1, 0, '0, 6'd63, '0,             "R3 read 63");
        step(0, 1, 0, '0, 6'd0,  '0,             "R3 read 0");
        step(0, 0, 0, '0, '0,    '0,             "R7 idle after read");
    endtask

    task automatic t_lanes();
        step(0, 1, 1, 4'b0101, 6'd9, '0,            "R4 write lanes 0,2");
        step(0, 1, 1, 4'b1000, 6'd9, 36'hF_FFFF_FFFF, "R4 write lane 3");
        step(0, 0, 0, '0,      '0,   36'h0_0000_0000, "R4 gap");
        step(0, 1, 0, '0,      6'd9, '0,            "R4 read merged");
        step(0, 0, 0, '0,      '0,   '0,            "R7 idle");
    endtask

    task automatic t_bypass();
        step(0, 1, 1, 4'b0011, 6'd12, '0,             "R5 write low lanes");
        step(0, 1, 0, '0,      6'd12, 36'hA_BCDE_F012, "R5 bypass read partial");
        step(0, 1, 1, '1,      6'd13, '0,             "R5 write full");
        step(0, 1, 0, '0,      6'd13, 36'h3_1415_9265, "R5 bypass read full");
        step(0, 1, 0, '0,      6'd12, '0,             "R5 array read after");
        step(0, 0, 0, '0,      '0,    '0,             "R7 idle");
    endtask

    task automatic t_b2b();
        step(0, 1, 1, '1,      6'd20, '0,             "R6 write 20");
        step(0, 1, 1, '1,      6'd21, 36'h1_1111_1111, "R6 write 21");
        step(0, 1, 1, 4'b0110, 6'd22, 36'h2_2222_2222, "R6 write 22");
        step(0, 1, 0, '0,      6'd20, 36'h3_3333_3333, "R6 read 20");
        step(0, 1, 0, '0,      6'd21, '0,             "R6 read 21");
        step(0, 1, 0, '0,      6'd22, '0,             "R6 read 22");
        step(0, 0, 0, '0,      '0,    '0,             "R7 idle");
    endtask

    task automatic t_idle();
        step(0, 0, 1, '1, 6'd30, 36'h7_7777_7777, "R7 deselected write");
        step(0, 0, 0, '1, 6'd30, 36'h8_8888_8888, "R7 deselected read");
        step(0, 0, 1, '1, 6'd30, 36'h9_9999_9999, "R7 deselected write");
        step(0, 1, 0, '0, 6'd30, 36'hA_AAAA_AAAA, "R7 contents kept");
        step(0, 0, 0, '0, '0,    '0,             "R7 idle");
    endtask

    task automatic t_sleep();
        step(0, 1, 0, '0, 6'd40, '0,             "R3 read before sleep");
        step(0, 1, 1, '1, 6'd7,  '0,             "R8 write before sleep");
        step(1, 1, 1, '1, 6'd41, 36'hC_0FFE_E123, "R8 sleep write ignored");
        step(1, 1, 0, '0, 6'd7,  36'hD_EAD0_BEEF, "R8 sleep read zero");
        step(0, 1, 0, '0, 6'd7,  36'hB_B0B0_B0B0, "R8 retained and completed");
        step(0, 1, 0, '0, 6'd41, '0,             "R8 ignored write left no trace");
        step(0, 0, 0, '0, '0,    '0,             "R7 idle");
    endtask

    task automatic t_reset_pending();
        step(0, 1, 1, '1, 6'd50, '0, "R1 write before reset");
        @(negedge clk);
        check(exp_tag, rd_data, exp_q);
        rst = 1'b1; sel = 1'b0; wr_data = 36'h6_6666_6666;
        pend_b = 1'b0; exp_q = '0; exp_tag = "R1 reset output";
        @(negedge clk);
        check("R1 reset output", rd_data, '0);
        rst = 1'b0;
        step(0, 1, 0, '0, 6'd50, '0, "R1 dropped write");
        step(0, 0, 0, '0, '0,    '0, "R7 idle");
    endtask

    task automatic t_width();
        check("R9 lane count", W'($bits(lane_en)), W'(4));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_init();
        t_basic();
        t_lanes();
        t_bypass();
        t_b2b();
        t_idle();
        t_sleep();
        t_reset_pending();
        t_width();
        step(0, 0, 0, '0, '0, '0, "R7 final idle");
        finish_run();
    end

endmodule